// File: doc/BRIEF.md
# Sequential Array Summation Engine

This block adds up a fixed-length array of words kept in an external memory, one word per loop pass. A single-cycle start pulse launches a run. The block clears its running total and its element counter, then steps through the array. For each element it tests the counter against the array length, issues a read with the counter as the address, captures the returned word, adds the word into the total, and advances the counter. When the counter reaches the array length, it raises a completion flag and holds the total on its output.

The block is a small controller that drives a datapath. The datapath has three registers: the total, the counter and the fetched element. Each register has a two-way input select that picks either its cleared value or its computed value. The datapath also has a less-than comparator against the length. A build parameter picks how the adds are done. One variant has a separate adder for the counter and a separate adder for the total. The other has a single adder, whose operands are steered by input selects, so the two adds must fall in different states. Both variants have the same cycle behaviour. The memory returns read data one clock after the strobe.

Top module: `array_summer`

## Requirements
- R1: While reset is asserted and after it is released, the completion flag is 0, the read strobe is 0, the total output is 0 and the address output is 0.
- R2: A start pulse seen while idle or complete clears the total and the counter. In the next cycle the completion flag is 0, and the first read of the run uses address 0.
- R3: A run issues exactly COUNT reads (default 128). Their addresses are 0, 1, …, COUNT-1 in ascending order. Each strobe lasts one cycle.
- R4: The word summed for a read is the value on the read-data input in the cycle after that read's strobe. Read-data values in any other cycle have no effect on the total.
- R5: The final total is the sum of the COUNT words, taken modulo 2^DATA_W (32 bits by default, wrapping on overflow).
- R6: The completion flag first reads high 5*COUNT+2 clock edges after the edge that sampled start. That is 642 edges for the default length: one for clearing, five per element, and one for the failing compare.
- R7: Once high, the completion flag stays high and the total stays unchanged for as long as start stays low.
- R8: A start pulse that arrives during a run is ignored. The run's total, its read sequence and its completion time are unchanged.
- R9: The single-adder build (SHARED_ADDER=1) produces the same totals, addresses and completion timing as the two-adder build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle run request |
| mem_addr_o | output | ADDR_W | Memory address, equal to the element counter |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the strobe |
| sum_o | output | DATA_W | Running or final total |
| done_o | output | 1 | Run complete |

## Verification
Both adder variants are run side by side on the same stimulus. The array contents used are all zeros, all ones, a ramp of the index values, large alternating values and seeded random words. All ones and the large words force the total to wrap, which exposes a truncated or mis-sized accumulator. The ramp exposes a wrong address order or a skipped or repeated element. Between valid reads the bench drives a junk value on the read-data input, so capturing in the wrong cycle changes the total. Start pulses are also given in the middle of a run, and a run is also restarted from the complete state, to separate ignored requests from accepted ones.

// File: rtl/array_summer_pkg.sv
package array_summer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_TEST  = 3'd2,
    ST_READ  = 3'd3,
    ST_GRAB  = 3'd4,
    ST_ADD   = 3'd5,
    ST_STEP  = 3'd6,
    ST_FIN   = 3'd7
  } sum_state_e;
endpackage

// File: rtl/asum_adder.sv
module asum_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  assign y_o = a_i + b_i;
endmodule

// File: rtl/asum_ctrl.sv
module asum_ctrl
  import array_summer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic below_i,
  output logic clr_sel_o,
  output logic tot_en_o,
  output logic cnt_en_o,
  output logic elem_en_o,
  output logic step_sel_o,
  output logic rd_o,
  output logic done_o
);
  sum_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    clr_sel_o  = 1'b0;
    tot_en_o   = 1'b0;
    cnt_en_o   = 1'b0;
    elem_en_o  = 1'b0;
    step_sel_o = 1'b0;
    rd_o       = 1'b0;
    done_o     = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CLEAR;
      ST_CLEAR: begin
        clr_sel_o = 1'b1;
        tot_en_o  = 1'b1;
        cnt_en_o  = 1'b1;
        elem_en_o = 1'b1;
        state_d   = ST_TEST;
      end
      ST_TEST:  state_d = below_i ? ST_READ : ST_FIN;
      ST_READ: begin
        rd_o    = 1'b1;
        state_d = ST_GRAB;
      end
      ST_GRAB: begin
        elem_en_o = 1'b1;
        state_d   = ST_ADD;
      end
      ST_ADD: begin
        tot_en_o = 1'b1;
        state_d  = ST_STEP;
      end
      ST_STEP: begin
        cnt_en_o   = 1'b1;
        step_sel_o = 1'b1;
        state_d    = ST_TEST;
      end
      ST_FIN: begin
        done_o = 1'b1;
        if (start_i) state_d = ST_CLEAR;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: no restart while a run is in flight
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_FIN) |=> state_q != ST_CLEAR);

  // R6: completion is entered only from a failing compare
  a_r6_done_from_test: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(state_q) == ST_TEST);

  // R7: completion persists while start is low
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/asum_datapath.sv
module asum_datapath #(
  parameter int DATA_W       = 32,
  parameter int COUNT        = 128,
  parameter bit SHARED_ADDER = 1'b0,
  parameter int CNT_W        = $clog2(COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_sel_i,
  input  logic              tot_en_i,
  input  logic              cnt_en_i,
  input  logic              elem_en_i,
  input  logic              step_sel_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              below_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] tot_o
);
  localparam logic [CNT_W-1:0] BOUND = CNT_W'(COUNT);

  logic [DATA_W-1:0] tot_q, elem_q, tot_next, tot_d, elem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_next, cnt_d;

  generate
    if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] op_a, op_b, op_y;
      assign op_a = step_sel_i ? {{(DATA_W-CNT_W){1'b0}}, cnt_q} : tot_q;
      assign op_b = step_sel_i ? DATA_W'(1) : elem_q;
      asum_adder #(.W(DATA_W)) u_add (.a_i(op_a), .b_i(op_b), .y_o(op_y));
      assign tot_next = op_y;
      assign cnt_next = op_y[CNT_W-1:0];
    end else begin : g_split
      logic unused_step_sel;
      assign unused_step_sel = step_sel_i;
      asum_adder #(.W(DATA_W)) u_add_tot (.a_i(tot_q), .b_i(elem_q), .y_o(tot_next));
      asum_adder #(.W(CNT_W))  u_add_cnt (.a_i(cnt_q), .b_i(CNT_W'(1)), .y_o(cnt_next));
    end
  endgenerate

  assign tot_d  = clr_sel_i ? '0 : tot_next;
  assign cnt_d  = clr_sel_i ? '0 : cnt_next;
  assign elem_d = clr_sel_i ? '0 : rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      cnt_q  <= '0;
      elem_q <= '0;
    end else begin
      if (tot_en_i)  tot_q  <= tot_d;
      if (cnt_en_i)  cnt_q  <= cnt_d;
      if (elem_en_i) elem_q <= elem_d;
    end
  end

  assign below_o = cnt_q < BOUND;
  assign cnt_o   = cnt_q;
  assign tot_o   = tot_q;

  // R3: the counter never passes the array length
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= BOUND);
endmodule

// File: rtl/array_summer.sv
module array_summer #(
  parameter int DATA_W       = 32,
  parameter int COUNT        = 128,
  parameter bit SHARED_ADDER = 1'b0,
  parameter int ADDR_W       = $clog2(COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(COUNT + 1);

  logic below, clr_sel, tot_en, cnt_en, elem_en, step_sel;
  logic [CNT_W-1:0] cnt;

  asum_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .below_i(below),
    .clr_sel_o(clr_sel), .tot_en_o(tot_en), .cnt_en_o(cnt_en),
    .elem_en_o(elem_en), .step_sel_o(step_sel), .rd_o(mem_rd_o),
    .done_o(done_o)
  );

  asum_datapath #(
    .DATA_W(DATA_W), .COUNT(COUNT), .SHARED_ADDER(SHARED_ADDER), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .clr_sel_i(clr_sel), .tot_en_i(tot_en),
    .cnt_en_i(cnt_en), .elem_en_i(elem_en), .step_sel_i(step_sel),
    .rdata_i(mem_rdata_i), .below_o(below), .cnt_o(cnt), .tot_o(sum_o)
  );

  assign mem_addr_o = cnt[ADDR_W-1:0];

  // R3: each read strobe lasts a single cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  // R7: the final total does not move while complete and idle
  a_r7_sum_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(sum_o));
endmodule

// File: tb/array_summer_test.sv
module array_summer_test;
  localparam int DW = 32;
  localparam int N  = 128;
  localparam int AW = 7;
  localparam int LAT = 5 * N + 2;
  localparam logic [DW-1:0] JUNK = 32'hBAD0_0BAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr_a, addr_b;
  logic rd_a, rd_b, done_a, done_b;
  logic [DW-1:0] rdata_a, rdata_b, sum_a, sum_b;
  logic [DW-1:0] mem [N];

  int total = 0, bad = 0;
  int reads_a = 0, reads_b = 0, addr_err_a = 0, addr_err_b = 0;

  always #5 clk = ~clk;

  array_summer #(.DATA_W(DW), .COUNT(N), .SHARED_ADDER(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mem_addr_o(addr_a),
    .mem_rd_o(rd_a), .mem_rdata_i(rdata_a), .sum_o(sum_a), .done_o(done_a));

  array_summer #(.DATA_W(DW), .COUNT(N), .SHARED_ADDER(1'b1)) uut_shared (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mem_addr_o(addr_b),
    .mem_rd_o(rd_b), .mem_rdata_i(rdata_b), .sum_o(sum_b), .done_o(done_b));

  // Memory model: data one cycle after strobe, junk otherwise (R4)
  always @(posedge clk) begin
    rdata_a <= rd_a ? mem[addr_a] : JUNK ^ {25'd0, addr_a};
    rdata_b <= rd_b ? mem[addr_b] : ~JUNK;
    if (rd_a) begin
      if (int'(addr_a) != reads_a % N) addr_err_a <= addr_err_a + 1;
      reads_a <= reads_a + 1;
    end
    if (rd_b) begin
      if (int'(addr_b) != reads_b % N) addr_err_b <= addr_err_b + 1;
      reads_b <= reads_b + 1;
    end
  end

  function automatic logic [DW-1:0] ref_sum();
    logic [DW-1:0] s = '0;
    for (int i = 0; i < N; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One run: start pulse, optional mid-run start at cycle poke (0 = none)
  task automatic run(string name, int poke);
    int cnt = 0, cnt_a = -1, cnt_b = -1;
    int ra0 = reads_a, rb0 = reads_b, ea0 = addr_err_a, eb0 = addr_err_b;
    logic [DW-1:0] exp = ref_sum();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check({"R2 done cleared ", name}, {31'd0, done_a | done_b}, '0);
    while ((cnt_a < 0 || cnt_b < 0) && cnt < LAT + 20) begin
      @(negedge clk);
      cnt++;
      start = (poke != 0 && cnt == poke);
      if (done_a && cnt_a < 0) cnt_a = cnt;
      if (done_b && cnt_b < 0) cnt_b = cnt;
    end
    start = 1'b0;
    check({"R6 latency ", name}, cnt_a, LAT);
    check({"R9 latency shared ", name}, cnt_b, LAT);
    check({"R5 sum ", name}, sum_a, exp);
    check({"R9 sum shared ", name}, sum_b, exp);
    check({"R3 read count ", name}, reads_a - ra0, N);
    check({"R9 read count shared ", name}, reads_b - rb0, N);
    check({"R3 address order ", name}, addr_err_a - ea0, 0);
    check({"R9 address order shared ", name}, addr_err_b - eb0, 0);
    if (poke != 0) check({"R8 busy start ignored ", name}, sum_a, exp);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 done in reset", {31'd0, done_a}, '0);
    check("R1 sum in reset", sum_a, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 strobe after reset", {31'd0, rd_a | rd_b}, '0);
    check("R1 addr after reset", {25'd0, addr_a}, '0);
    check("R1 sum after reset", sum_b, '0);

    run("zeros", 0);
    for (int i = 0; i < N; i++) mem[i] = '1;
    run("ones wrap", 0);
    // R7: hold after completion
    repeat (25) @(negedge clk);
    check("R7 done holds", {31'd0, done_a & done_b}, 32'd1);
    check("R7 sum holds", sum_a, 32'hFFFF_FF80);
    for (int i = 0; i < N; i++) mem[i] = DW'(i);
    run("ramp", 0);
    for (int i = 0; i < N; i++) mem[i] = (i % 2 == 0) ? 32'h8000_0001 : 32'h7FFF_FFFE;
    run("alternating", 300);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) mem[i] = $urandom;
      run("random", 7 + 211 * k);
    end
    // R4: junk between strobes never reaches the total: zeros give zero
    for (int i = 0; i < N; i++) mem[i] = '0;
    run("R4 junk ignored", 0);
    // R1: reset mid-run returns to idle
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset done", {31'd0, done_a | done_b}, '0);
    check("R1 mid-run reset sum", sum_a | sum_b, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule